// File: doc/BRIEF.md
# Command Ring Consumer

This block drains a circular queue of 32-bit command words kept in a shared, word-addressed memory. The queue's bookkeeping lives inside that same memory. Four header words hold the lower and upper bounds of the ring area, the producer's write pointer and the consumer's read pointer. All four are byte offsets. A producer appends words and moves its write pointer. This block fetches words at its read pointer, advances the pointer, wraps it back to the lower bound, and writes it back into the header after every word.

Software starts a drain session with a one-cycle start request. The block then parses opcodes and collects their argument words. Area updates, solid fills, area copies and cursor definitions are handed to a drawing engine as a parameter bundle with a valid/ready handshake. Other commands whose length is known are consumed without effect, so that the stream stays aligned. The session ends, and the busy flag drops, when an opcode boundary finds the ring empty.

Top module: `cring_consumer`

## Requirements
- R1: After reset, busy and cmd_valid are low and no memory access is made until a start request arrives.
- R2: The ring is empty when cfg_done is low, when enable is low, or when header word 2 (write pointer) equals the read pointer. An empty ring at an opcode boundary ends the session: busy drops, nothing is dispatched and the read pointer is not changed.
- R3: Header words are: word 0 lower bound, word 1 upper bound, word 2 write pointer, word 3 read pointer, all byte offsets. Each fetch reads the word at index (read pointer / 4), adds 4 to the read pointer and writes the new value to word 3.
- R4: When the advanced read pointer is greater than or equal to the upper bound, it becomes the lower bound instead.
- R5: Opcodes 1 and 25 take four arguments (x, y, w, h) and are dispatched with kind 0, with the arguments in slots 0 to 3.
- R6: Opcode 2 takes five arguments (colour, x, y, w, h) and is dispatched with kind 1, slots 0 to 4.
- R7: Opcode 3 takes six arguments (source x, source y, destination x, destination y, w, h) and is dispatched with kind 2, slots 0 to 5.
- R8: Opcode 19 reads seven words into slots 0 to 6 (id, hot x, hot y, width, height, unused, bits per pixel). It then consumes ((width+31)>>5)*height mask words and ((width*bpp+31)>>5)*height image words, and is dispatched with kind 3.
- R9: Opcodes 13, 14 and 28 raise unsup for one cycle with the opcode on unsup_op. They then consume 6, 7 and 12 further words and dispatch nothing.
- R10: Opcode 22 raises unsup, reads five words and then consumes word4*word5 more. Opcode 24 raises unsup, reads three words and then consumes 7+(word3>>2) more. Neither dispatches.
- R11: Opcodes 0, 26, 27, 29 and 30 consume only themselves, with no dispatch and no flag. Any other opcode consumes one word and raises unsup.
- R12: If the ring empties partway through a command, the block keeps busy high and waits for more words without ending the session.
- R13: A bundle stays valid with stable kind and arguments until cmd_ready is high, and it is delivered exactly once.
- R14: A start request in the same cycle as an empty ring at an opcode boundary keeps busy high and polls the ring again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Ring memory configured |
| enable | input | 1 | Device enabled |
| kick | input | 1 | Start (or continue) a drain session |
| busy | output | 1 | Drain session in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| cmd_valid | output | 1 | Bundle available |
| cmd_ready | input | 1 | Engine accepts bundle |
| cmd_kind | output | 2 | 0 update, 1 fill, 2 copy, 3 cursor |
| cmd_args | output | 224 | Slot i at bits 32*i+31 to 32*i |
| unsup | output | 1 | One-cycle flag for a skipped or unknown opcode |
| unsup_op | output | 32 | Opcode that raised unsup |

## Verification
Two events can fall in the same cycle: the empty ring that ends a session and a fresh start request. The bench provokes this by holding kick high across an empty ring, so the empty poll is bound to coincide with a request. It judges the result by checking that busy stays high and that a command written later is consumed without another request. Once kick drops, the bench checks that busy falls. A further check runs a full opcode table, where each command is followed by a marker update. A correct marker bundle and a correct final read pointer in header word 3 show that skip lengths and wraparound left the stream aligned.

// File: rtl/cring_pkg.sv
package cring_pkg;
    localparam int WORD_W = 32;
    localparam int SLOTS  = 7;

    localparam int HDR_LO   = 0;
    localparam int HDR_HI   = 1;
    localparam int HDR_PROD = 2;
    localparam int HDR_CONS = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [SLOTS-1:0] slots_t;

    localparam word_t OP_NOP0    = 32'd0;
    localparam word_t OP_UPD     = 32'd1;
    localparam word_t OP_FILL    = 32'd2;
    localparam word_t OP_COPY    = 32'd3;
    localparam word_t OP_SKIP6   = 32'd13;
    localparam word_t OP_SKIP7   = 32'd14;
    localparam word_t OP_CURSOR  = 32'd19;
    localparam word_t OP_ACURSOR = 32'd22;
    localparam word_t OP_GLYPH   = 32'd24;
    localparam word_t OP_UPD2    = 32'd25;
    localparam word_t OP_NOP26   = 32'd26;
    localparam word_t OP_NOP27   = 32'd27;
    localparam word_t OP_SKIP12  = 32'd28;
    localparam word_t OP_NOP29   = 32'd29;
    localparam word_t OP_NOP30   = 32'd30;

    typedef enum logic [1:0] {K_UPDATE = 2'd0, K_FILL = 2'd1, K_COPY = 2'd2, K_CURSOR = 2'd3} kind_e;
    typedef enum logic [1:0] {C_DRAW, C_SKIP, C_NOP, C_BAD} class_e;

    typedef struct packed {
        class_e     cls;
        kind_e      kind;
        logic [2:0] nhdr;
    } opinfo_t;

    function automatic opinfo_t decode_op(word_t op);
        opinfo_t r;
        r.cls  = C_BAD;
        r.kind = K_UPDATE;
        r.nhdr = 3'd0;
        case (op)
            OP_UPD, OP_UPD2: begin r.cls = C_DRAW; r.kind = K_UPDATE; r.nhdr = 3'd4; end
            OP_FILL:         begin r.cls = C_DRAW; r.kind = K_FILL;   r.nhdr = 3'd5; end
            OP_COPY:         begin r.cls = C_DRAW; r.kind = K_COPY;   r.nhdr = 3'd6; end
            OP_CURSOR:       begin r.cls = C_DRAW; r.kind = K_CURSOR; r.nhdr = 3'd7; end
            OP_SKIP6, OP_SKIP7, OP_SKIP12: r.cls = C_SKIP;
            OP_ACURSOR:      begin r.cls = C_SKIP; r.nhdr = 3'd5; end
            OP_GLYPH:        begin r.cls = C_SKIP; r.nhdr = 3'd3; end
            OP_NOP0, OP_NOP26, OP_NOP27, OP_NOP29, OP_NOP30: r.cls = C_NOP;
            default:         r.cls = C_BAD;
        endcase
        return r;
    endfunction

    // Words still to be consumed after the header words of a command.
    function automatic word_t tail_words(word_t op, slots_t a);
        word_t r;
        case (op)
            OP_CURSOR:  r = (((a[3] + 32'd31) >> 5) * a[4])
                          + ((((a[3] * a[6]) + 32'd31) >> 5) * a[4]);
            OP_SKIP6:   r = 32'd6;
            OP_SKIP7:   r = 32'd7;
            OP_SKIP12:  r = 32'd12;
            OP_ACURSOR: r = a[3] * a[4];
            OP_GLYPH:   r = 32'd7 + (a[2] >> 2);
            default:    r = 32'd0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cring_fetch.sv
module cring_fetch
    import cring_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              word_req,
    input  logic              sess_end,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output word_t             mem_wdata,
    input  word_t             mem_rdata,
    output logic              word_valid,
    output word_t             word_data,
    output logic              ring_empty
);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(HDR_LO);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(HDR_HI);
    localparam logic [ADDR_W-1:0] A_PROD = ADDR_W'(HDR_PROD);
    localparam logic [ADDR_W-1:0] A_CONS = ADDR_W'(HDR_CONS);

    typedef enum logic [2:0] {F_IDLE, F_LO, F_HI, F_CONS, F_CHK, F_GET} fst_e;

    fst_e  st, st_d;
    word_t lo_q, hi_q, cons_q, cons_nx;
    logic  hdr_ok;

    always_comb begin
        cons_nx = cons_q + 32'd4;
        if (cons_nx >= hi_q) cons_nx = lo_q;
    end

    always_comb begin
        st_d       = st;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        word_valid = 1'b0;
        ring_empty = 1'b0;
        word_data  = mem_rdata;
        case (st)
            F_IDLE: if (word_req) begin
                if (!run) begin
                    ring_empty = 1'b1;
                end else if (!hdr_ok) begin
                    mem_req = 1'b1; mem_addr = A_LO; st_d = F_LO;
                end else begin
                    mem_req = 1'b1; mem_addr = A_PROD; st_d = F_CHK;
                end
            end
            F_LO:   begin mem_req = 1'b1; mem_addr = A_HI;   st_d = F_HI;   end
            F_HI:   begin mem_req = 1'b1; mem_addr = A_CONS; st_d = F_CONS; end
            F_CONS: begin mem_req = 1'b1; mem_addr = A_PROD; st_d = F_CHK;  end
            F_CHK: begin
                if (mem_rdata == cons_q) begin
                    ring_empty = 1'b1;
                    st_d = F_IDLE;
                end else begin
                    mem_req  = 1'b1;
                    mem_addr = cons_q[ADDR_W+1:2];
                    st_d     = F_GET;
                end
            end
            F_GET: begin
                word_valid = 1'b1;
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = A_CONS;
                mem_wdata  = cons_nx;
                st_d       = F_IDLE;
            end
            default: st_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= F_IDLE;
            lo_q   <= '0;
            hi_q   <= '0;
            cons_q <= '0;
            hdr_ok <= 1'b0;
        end else begin
            st <= st_d;
            case (st)
                F_LO:   lo_q <= mem_rdata;
                F_HI:   hi_q <= mem_rdata;
                F_CONS: begin cons_q <= mem_rdata; hdr_ok <= 1'b1; end
                F_GET:  cons_q <= cons_nx;
                default: ;
            endcase
            if (sess_end) hdr_ok <= 1'b0;
        end
    end

    AST_WE_CONS_ONLY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == A_CONS)) else $error("write outside read-pointer word"); // R3
    AST_WRAP_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ((mem_wdata == lo_q) || (mem_wdata < hi_q))) else $error("pointer left ring"); // R4
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({word_valid, ring_empty})) else $error("word and empty together"); // R2
endmodule

// File: rtl/cring_parser.sv
module cring_parser
    import cring_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   kick,
    input  logic   word_valid,
    input  word_t  word_data,
    input  logic   ring_empty,
    input  logic   cmd_ready,
    output logic   word_req,
    output logic   sess_end,
    output logic   busy,
    output logic   cmd_valid,
    output kind_e  cmd_kind,
    output slots_t cmd_args,
    output logic   unsup,
    output word_t  unsup_op
);
    typedef enum logic [2:0] {P_IDLE, P_OP, P_ARG, P_TAIL, P_SEND} pst_e;

    pst_e       st;
    opinfo_t    info_q, info_w;
    word_t      op_q, cnt_q, tail_w;
    slots_t     args_q, args_w;
    logic [2:0] idx_q;
    logic       last_hdr;

    always_comb begin
        info_w         = decode_op(word_data);
        args_w         = args_q;
        args_w[idx_q]  = word_data;
        last_hdr       = (idx_q == (info_q.nhdr - 3'd1));
        tail_w         = (st == P_OP) ? tail_words(word_data, '0) : tail_words(op_q, args_w);
    end

    assign word_req  = (st == P_OP) || (st == P_ARG) || (st == P_TAIL);
    assign sess_end  = (st == P_OP) && ring_empty && !kick;
    assign busy      = (st != P_IDLE);
    assign cmd_valid = (st == P_SEND);
    assign cmd_kind  = info_q.kind;
    assign cmd_args  = args_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= P_IDLE;
            info_q   <= '0;
            op_q     <= '0;
            cnt_q    <= '0;
            args_q   <= '0;
            idx_q    <= '0;
            unsup    <= 1'b0;
            unsup_op <= '0;
        end else begin
            unsup <= 1'b0;
            case (st)
                P_IDLE: if (kick) st <= P_OP;
                P_OP: begin
                    if (ring_empty) begin
                        if (!kick) st <= P_IDLE;
                    end else if (word_valid) begin
                        op_q   <= word_data;
                        info_q <= info_w;
                        args_q <= '0;
                        idx_q  <= '0;
                        if (info_w.cls == C_SKIP || info_w.cls == C_BAD) begin
                            unsup    <= 1'b1;
                            unsup_op <= word_data;
                        end
                        if (info_w.nhdr != 3'd0) begin
                            st <= P_ARG;
                        end else if (tail_w != '0) begin
                            cnt_q <= tail_w;
                            st    <= P_TAIL;
                        end
                    end
                end
                P_ARG: if (word_valid) begin
                    args_q <= args_w;
                    idx_q  <= idx_q + 3'd1;
                    if (last_hdr) begin
                        if (tail_w != '0) begin
                            cnt_q <= tail_w;
                            st    <= P_TAIL;
                        end else if (info_q.cls == C_DRAW) begin
                            st <= P_SEND;
                        end else begin
                            st <= P_OP;
                        end
                    end
                end
                P_TAIL: if (word_valid) begin
                    cnt_q <= cnt_q - 32'd1;
                    if (cnt_q == 32'd1) st <= (info_q.cls == C_DRAW) ? P_SEND : P_OP;
                end
                P_SEND: if (cmd_ready) st <= P_OP;
                default: st <= P_IDLE;
            endcase
        end
    end

    AST_HOLD_BUNDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_args) && $stable(cmd_kind))) else $error("bundle dropped"); // R13
    AST_WAIT_MIDCMD: assert property (@(posedge clk) disable iff (rst)
        ((st == P_ARG || st == P_TAIL) && ring_empty) |=> busy) else $error("session ended mid-command"); // R12
    AST_KICK_WINS: assert property (@(posedge clk) disable iff (rst)
        ((st == P_OP) && ring_empty && kick) |=> busy) else $error("busy dropped under start request"); // R14
endmodule

// File: rtl/cring_consumer.sv
module cring_consumer
    import cring_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_done,
    input  logic                    enable,
    input  logic                    kick,
    output logic                    busy,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORD_W-1:0]       mem_wdata,
    input  logic [WORD_W-1:0]       mem_rdata,
    output logic                    cmd_valid,
    input  logic                    cmd_ready,
    output logic [1:0]              cmd_kind,
    output logic [SLOTS*WORD_W-1:0] cmd_args,
    output logic                    unsup,
    output logic [WORD_W-1:0]       unsup_op
);
    logic   word_req, sess_end, word_valid, ring_empty;
    word_t  word_data;
    kind_e  kind_w;
    slots_t args_w;

    cring_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .run        (cfg_done & enable),
        .word_req   (word_req),
        .sess_end   (sess_end),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .word_valid (word_valid),
        .word_data  (word_data),
        .ring_empty (ring_empty)
    );

    cring_parser u_parser (
        .clk        (clk),
        .rst        (rst),
        .kick       (kick),
        .word_valid (word_valid),
        .word_data  (word_data),
        .ring_empty (ring_empty),
        .cmd_ready  (cmd_ready),
        .word_req   (word_req),
        .sess_end   (sess_end),
        .busy       (busy),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (kind_w),
        .cmd_args   (args_w),
        .unsup      (unsup),
        .unsup_op   (unsup_op)
    );

    assign cmd_kind = kind_w;
    assign cmd_args = args_w;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req) else $error("memory access outside session"); // R2
    AST_NO_WRITE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!cfg_done || !enable) |-> !(mem_req && mem_addr != ADDR_W'(HDR_CONS) && $past(!busy))) else $error("fetch while disabled"); // R2
endmodule

// File: tb/cring_consumer_bench.sv
module cring_consumer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] p0, p1, p2, p3, p4, p5, p6;
        logic [7:0]  words;
        logic [2:0]  kind;
        logic        unsup;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{8'd1,   16'd1,  16'd2, 16'd3,  16'd4,  16'd0, 16'd0, 16'd0, 8'd5,  3'd0, 1'b0},
        '{8'd25,  16'd11, 16'd12,16'd13, 16'd14, 16'd0, 16'd0, 16'd0, 8'd5,  3'd0, 1'b0},
        '{8'd2,   16'hABC,16'd5, 16'd6,  16'd7,  16'd8, 16'd0, 16'd0, 8'd6,  3'd1, 1'b0},
        '{8'd3,   16'd21, 16'd22,16'd23, 16'd24, 16'd25,16'd26,16'd0, 8'd7,  3'd2, 1'b0},
        '{8'd19,  16'd3,  16'd1, 16'd2,  16'd40, 16'd2, 16'd0, 16'd8, 8'd32, 3'd3, 1'b0},
        '{8'd13,  16'd1,  16'd1, 16'd1,  16'd1,  16'd1, 16'd1, 16'd0, 8'd7,  3'd7, 1'b1},
        '{8'd14,  16'd1,  16'd1, 16'd1,  16'd1,  16'd1, 16'd1, 16'd1, 8'd8,  3'd7, 1'b1},
        '{8'd28,  16'd5,  16'd5, 16'd5,  16'd5,  16'd5, 16'd5, 16'd5, 8'd13, 3'd7, 1'b1},
        '{8'd22,  16'd0,  16'd0, 16'd0,  16'd3,  16'd4, 16'd9, 16'd9, 8'd18, 3'd7, 1'b1},
        '{8'd24,  16'd0,  16'd0, 16'd10, 16'd9,  16'd9, 16'd9, 16'd9, 8'd13, 3'd7, 1'b1},
        '{8'd0,   16'd0,  16'd0, 16'd0,  16'd0,  16'd0, 16'd0, 16'd0, 8'd1,  3'd7, 1'b0},
        '{8'd26,  16'd0,  16'd0, 16'd0,  16'd0,  16'd0, 16'd0, 16'd0, 8'd1,  3'd7, 1'b0},
        '{8'd27,  16'd0,  16'd0, 16'd0,  16'd0,  16'd0, 16'd0, 16'd0, 8'd1,  3'd7, 1'b0},
        '{8'd29,  16'd0,  16'd0, 16'd0,  16'd0,  16'd0, 16'd0, 16'd0, 8'd1,  3'd7, 1'b0},
        '{8'd30,  16'd0,  16'd0, 16'd0,  16'd0,  16'd0, 16'd0, 16'd0, 8'd1,  3'd7, 1'b0},
        '{8'd7,   16'd0,  16'd0, 16'd0,  16'd0,  16'd0, 16'd0, 16'd0, 8'd1,  3'd7, 1'b1},
        '{8'd255, 16'd0,  16'd0, 16'd0,  16'd0,  16'd0, 16'd0, 16'd0, 8'd1,  3'd7, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_done = 1'b1, enable = 1'b1, kick = 1'b0;
    logic busy, mem_req, mem_we, cmd_valid, unsup;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, unsup_op;
    logic cmd_ready = 1'b1;
    logic [1:0] cmd_kind;
    logic [223:0] cmd_args;

    logic [31:0] mem [1024];
    logic bd_we = 1'b0;
    logic [AW-1:0] bd_addr = '0;
    logic [31:0] bd_data = '0;
    logic stall = 1'b0;
    int cyc = 0;

    int n_chk = 0, n_bad = 0;
    int rec_n = 0, uns_n = 0;
    logic [1:0]   rec_kind [64];
    logic [223:0] rec_args [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    cring_consumer #(.ADDR_W(AW)) u_cring_consumer (
        .clk(clk), .rst(rst), .cfg_done(cfg_done), .enable(enable), .kick(kick),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_args(cmd_args),
        .unsup(unsup), .unsup_op(unsup_op)
    );

    always @(posedge clk) begin
        if (bd_we) mem[bd_addr] <= bd_data;
        else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
        cyc <= cyc + 1;
        cmd_ready <= stall ? (cyc[1:0] == 2'b11) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid && cmd_ready) begin
                rec_kind[rec_n % 64] = cmd_kind;
                rec_args[rec_n % 64] = cmd_args;
                rec_n++;
            end
            if (unsup) uns_n++;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bd_we = 1'b1; bd_addr = AW'(a); bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic set_hdr(input int lo, input int hi, input int cons, input int prod);
        wr(0, lo); wr(1, hi); wr(3, cons); wr(2, prod);
    endtask

    task automatic run_ring();
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    function automatic logic [15:0] pv(vec_t v, int i);
        case (i)
            0: return v.p0; 1: return v.p1; 2: return v.p2; 3: return v.p3;
            4: return v.p4; 5: return v.p5; default: return v.p6;
        endcase
    endfunction

    function automatic string tag(logic [7:0] op);
        case (op)
            8'd1, 8'd25: return "R5";
            8'd2: return "R6";
            8'd3: return "R7";
            8'd19: return "R8";
            8'd13, 8'd14, 8'd28: return "R9";
            8'd22, 8'd24: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int nslots(logic [2:0] k);
        case (k)
            3'd0: return 4; 3'd1: return 5; 3'd2: return 6; default: return 7;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
        chk(cmd_valid == 1'b0, "R1 cmd_valid", 32'(cmd_valid), 0);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0, "R1 idle after reset", 32'(busy), 0);

        // opcode table
        for (int k = 0; k < NV; k++) begin
            automatic vec_t v = VECS[k];
            automatic int w = int'(v.words);
            automatic int prod = 16 + 4 * (w + 5);
            automatic int rb = rec_n, ub = uns_n;
            automatic int ndisp = (v.kind == 3'd7) ? 1 : 2;
            wr(4, {24'd0, v.op});
            for (int i = 1; i < w; i++) wr(4 + i, (i <= 7) ? {16'd0, pv(v, i - 1)} : 32'hF00D_0000 + i);
            wr(4 + w, 1); wr(5 + w, 9); wr(6 + w, 8); wr(7 + w, 7); wr(8 + w, 6);
            set_hdr(16, 4096, 16, prod);
            run_ring();
            chk(busy == 1'b0, "R2 drained", 32'(busy), 0);
            chk(mem[3] == prod, "R3 read pointer", mem[3], prod);
            chk(uns_n - ub == int'(v.unsup), tag(v.op), uns_n - ub, 32'(v.unsup));
            chk(rec_n - rb == ndisp, tag(v.op), rec_n - rb, ndisp);
            if (rec_n - rb == ndisp) begin
                if (ndisp == 2) begin
                    chk(rec_kind[rb % 64] == v.kind[1:0], tag(v.op), 32'(rec_kind[rb % 64]), 32'(v.kind));
                    for (int i = 0; i < nslots(v.kind); i++)
                        chk(rec_args[rb % 64][32*i +: 32] == {16'd0, pv(v, i)}, tag(v.op),
                            rec_args[rb % 64][32*i +: 32], {16'd0, pv(v, i)});
                end
                chk(rec_kind[(rec_n - 1) % 64] == 2'd0 && rec_args[(rec_n - 1) % 64][127:0] == {32'd6, 32'd7, 32'd8, 32'd9},
                    tag(v.op), rec_args[(rec_n - 1) % 64][31:0], 9);
            end
        end

        // R4 wrap: ring words 4..15, read pointer starts at byte 56
        begin
            automatic int rb = rec_n;
            wr(14, 1); wr(15, 31); wr(4, 32); wr(5, 33); wr(6, 34);
            set_hdr(16, 64, 56, 28);
            run_ring();
            chk(mem[3] == 28, "R4 wrapped pointer", mem[3], 28);
            chk(rec_n - rb == 1, "R4 dispatch", rec_n - rb, 1);
            chk(rec_args[rb % 64][127:0] == {32'd34, 32'd33, 32'd32, 32'd31}, "R4 args across wrap",
                rec_args[rb % 64][31:0], 31);
        end

        // R2 disabled / unconfigured
        for (int m = 0; m < 2; m++) begin
            automatic int rb = rec_n;
            enable = (m == 1); cfg_done = (m == 0);
            wr(4, 1); wr(5, 1); wr(6, 2); wr(7, 3); wr(8, 4);
            set_hdr(16, 4096, 16, 36);
            run_ring();
            chk(busy == 1'b0, "R2 disabled busy", 32'(busy), 0);
            chk(rec_n == rb, "R2 disabled dispatch", rec_n - rb, 0);
            chk(mem[3] == 16, "R2 disabled pointer", mem[3], 16);
        end
        enable = 1'b1; cfg_done = 1'b1;

        // R12 ring runs dry inside a command
        begin
            automatic int rb = rec_n;
            wr(4, 2); wr(5, 70); wr(6, 71);
            set_hdr(16, 4096, 16, 28);
            kick = 1'b1; @(negedge clk); kick = 1'b0;
            repeat (60) @(negedge clk);
            chk(busy == 1'b1, "R12 waits", 32'(busy), 1);
            chk(rec_n == rb, "R12 no early dispatch", rec_n - rb, 0);
            chk(mem[3] == 28, "R12 pointer", mem[3], 28);
            wr(7, 72); wr(8, 73); wr(9, 74); wr(2, 40);
            for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
            chk(rec_n - rb == 1 && rec_kind[rb % 64] == 2'd1, "R12 completes", rec_n - rb, 1);
            chk(rec_args[rb % 64][159:0] == {32'd74, 32'd73, 32'd72, 32'd71, 32'd70}, "R12 args",
                rec_args[rb % 64][31:0], 70);
        end

        // R13 backpressure
        begin
            automatic int rb = rec_n;
            stall = 1'b1;
            wr(4, 3); for (int i = 0; i < 6; i++) wr(5 + i, 100 + i);
            set_hdr(16, 4096, 16, 44);
            run_ring();
            stall = 1'b0;
            chk(rec_n - rb == 1, "R13 once", rec_n - rb, 1);
            chk(rec_args[rb % 64][191:160] == 105 && rec_args[rb % 64][31:0] == 100, "R13 args",
                rec_args[rb % 64][191:160], 105);
        end

        // R14 start request held across the empty poll
        begin
            automatic int rb = rec_n;
            set_hdr(16, 4096, 16, 16);
            kick = 1'b1;
            repeat (30) @(negedge clk);
            chk(busy == 1'b1, "R14 busy held", 32'(busy), 1);
            wr(4, 25); wr(5, 1); wr(6, 2); wr(7, 3); wr(8, 4); wr(2, 36);
            repeat (60) @(negedge clk);
            chk(rec_n - rb == 1, "R14 consumed without new request", rec_n - rb, 1);
            kick = 1'b0;
            for (int i = 0; i < 50 && busy; i++) @(negedge clk);
            chk(busy == 1'b0, "R14 drains after release", 32'(busy), 0);
        end

        summary();
    end
endmodule